// File: doc/BRIEF.md
# Capture FIFO Read-Side Status Decoder

This block sits between the read port of a video capture FIFO and a DMA sequencer. Every 36-bit word leaving the FIFO carries a 32-bit pixel DWORD in bits 31:0 and a 4-bit in-band status code in bits 35:32. The decoder passes the DWORD through unchanged. In the same cycle it produces the PCI-style active-low byte enables for that DWORD and one-cycle event flags: format mode change, start of line, end of line, end of even field, end of odd field, and undefined code.

The block also keeps a small line and field state. It counts the DWORDs accepted in the current line and compares that count with a programmed expected line length. A line that closes early raises a short-line flag. A line that reaches the expected length without closing raises a long-line flag. Field boundaries and mode words clear the line state, so a sequencer that sees these flags can drop or pad and pick up again at the next framing code.

Both stream sides use valid/ready. The decoder is a zero-latency pass-through: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and a word counts as consumed only in a cycle where both are high. When the sink holds `out_ready` low, the word, its byte enables and its event flags stay presented. No state advances until the transfer completes.

Top module: `capdec_top`

## Requirements
- R1: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` equals `in_word[31:0]` in the same cycle. A word counts as transferred only when `in_valid` and `out_ready` are both high.
- R2: End-of-line codes in `in_word[35:32]` give low-order active-low byte enables: 4'b0001 gives `out_be_n` 4'b0000, 4'b1101 gives 4'b1000, 4'b1001 gives 4'b1100, and 4'b0101 gives 4'b1110. Each of these codes raises `ev_eol`.
- R3: Code 4'b0000 is a plain pixel DWORD with `out_be_n` 4'b0000 and no event. Code 4'b0010 raises `ev_sol` with `out_be_n` 4'b0000.
- R4: Code 4'b0110 raises `ev_mode` with `mode_planar` low (packed). Code 4'b1110 raises `ev_mode` with `mode_planar` high. Both give `out_be_n` 4'b1111, and once transferred they set `field_active` on the next cycle.
- R5: Code 4'b0100 raises `ev_even_end` and code 4'b1100 raises `ev_odd_end`, both with `out_be_n` 4'b1111. Once transferred, either one clears both `line_active` and `field_active` on the next cycle.
- R6: Every other code raises `ev_err` with `out_be_n` 4'b0000. It leaves the line state and the DWORD count unchanged.
- R7: When an end-of-line word is at position p in its line and p is less than `exp_dwords`, `short_line` is high in that word's cycle. The line position counts the start word as 1 and each pixel DWORD after it.
- R8: When a pixel DWORD inside an open line lands at position p equal to `exp_dwords`, `long_line` is high in that cycle. The flag fires only once per line.
- R9: `line_active` rises on the cycle after a start-of-line word is transferred. It falls after an end-of-line, mode or field-end word. Pixel DWORDs outside a line do not open one.
- R10: After reset `line_active` and `field_active` are low.
- R11: A word presented while `out_ready` is low does not change the line count or the line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | FIFO word present |
| in_ready | output | 1 | Decoder can take the word |
| in_word | input | 36 | Status in [35:32], DWORD in [31:0] |
| out_valid | output | 1 | Output DWORD present |
| out_ready | input | 1 | Sink takes the DWORD |
| out_data | output | 32 | Pixel DWORD |
| out_be_n | output | 4 | Active-low byte enables |
| exp_dwords | input | CNT_W | Expected DWORDs per line |
| ev_mode | output | 1 | Mode word present |
| mode_planar | output | 1 | Mode is planar (1) or packed (0) |
| ev_sol | output | 1 | First DWORD of a line |
| ev_eol | output | 1 | Last DWORD of a line |
| ev_even_end | output | 1 | End of even field |
| ev_odd_end | output | 1 | End of odd field |
| ev_err | output | 1 | Undefined status code |
| short_line | output | 1 | Line closed before expected length |
| long_line | output | 1 | Line reached expected length without closing |
| line_active | output | 1 | Inside a line |
| field_active | output | 1 | Inside a capture field |

## Verification
Data, byte enables, event flags and the short/long flags are combinational functions of the presented word and the registered line count, so they are due in the same cycle the word is driven. The bench drives each word just after a falling edge and samples 1 ns later, before the next rising edge. `line_active` and `field_active` are due one rising edge after the word is transferred. The bench reads them after an idle half-cycle that follows that edge. The effect of a stall, and of an undefined code inside a line, is observed through where `long_line` fires later in the same line.

// File: rtl/capdec_pkg.sv
package capdec_pkg;

  typedef enum logic [3:0] {
    ST_PIX   = 4'b0000,
    ST_END4  = 4'b0001,
    ST_END3  = 4'b1101,
    ST_END2  = 4'b1001,
    ST_END1  = 4'b0101,
    ST_START = 4'b0010,
    ST_PACK  = 4'b0110,
    ST_PLAN  = 4'b1110,
    ST_EVEN  = 4'b0100,
    ST_ODD   = 4'b1100
  } stat_e;

  typedef struct packed {
    logic mode;
    logic planar;
    logic sol;
    logic eol;
    logic even_end;
    logic odd_end;
    logic err;
    logic pix;
  } evt_t;

endpackage

// File: rtl/capdec_decode.sv
module capdec_decode
  import capdec_pkg::*;
(
  input  logic [3:0] code,
  output evt_t       ev,
  output logic [3:0] be_n
);

  always_comb begin
    ev   = '0;
    be_n = 4'b0000;
    case (code)
      ST_PIX:   ev.pix = 1'b1;
      ST_START: ev.sol = 1'b1;
      ST_END4:  ev.eol = 1'b1;
      ST_END3: begin ev.eol = 1'b1; be_n = 4'b1000; end
      ST_END2: begin ev.eol = 1'b1; be_n = 4'b1100; end
      ST_END1: begin ev.eol = 1'b1; be_n = 4'b1110; end
      ST_PACK: begin ev.mode = 1'b1; be_n = 4'b1111; end
      ST_PLAN: begin ev.mode = 1'b1; ev.planar = 1'b1; be_n = 4'b1111; end
      ST_EVEN: begin ev.even_end = 1'b1; be_n = 4'b1111; end
      ST_ODD:  begin ev.odd_end = 1'b1; be_n = 4'b1111; end
      default: ev.err = 1'b1;
    endcase
  end

endmodule

// File: rtl/capdec_line.sv
module capdec_line #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             is_mode,
  input  logic             is_fend,
  input  logic             is_sol,
  input  logic             is_eol,
  input  logic             is_pix,
  input  logic [CNT_W-1:0] exp_dwords,
  output logic             line_active,
  output logic             field_active,
  output logic             short_line,
  output logic             long_line
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   POS_ONE = (CNT_W+1)'(1);

  logic             line_q, field_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   pos;
  logic [CNT_W:0]   exp_w;

  assign exp_w = {1'b0, exp_dwords};
  assign pos   = (is_sol || !line_q) ? POS_ONE : ({1'b0, cnt_q} + POS_ONE);

  assign short_line = is_eol && (pos < exp_w);
  assign long_line  = is_pix && line_q && (pos == exp_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      field_q <= 1'b0;
      cnt_q   <= '0;
    end else if (acc) begin
      if (is_mode) begin
        field_q <= 1'b1;
        line_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (is_fend) begin
        field_q <= 1'b0;
        line_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (is_sol) begin
        line_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end else if (is_eol) begin
        line_q <= 1'b0;
        cnt_q  <= '0;
      end else if (is_pix && line_q && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign line_active  = line_q;
  assign field_active = field_q;

  assert_sol_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_sol) |=> line_active);

  assert_fend_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_fend) |=> (!line_active && !field_active));

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(cnt_q) && $stable(line_q)));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_line && long_line));

endmodule

// File: rtl/capdec_top.sv
module capdec_top
  import capdec_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [35:0]      in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic [3:0]       out_be_n,
  input  logic [CNT_W-1:0] exp_dwords,
  output logic             ev_mode,
  output logic             mode_planar,
  output logic             ev_sol,
  output logic             ev_eol,
  output logic             ev_even_end,
  output logic             ev_odd_end,
  output logic             ev_err,
  output logic             short_line,
  output logic             long_line,
  output logic             line_active,
  output logic             field_active
);

  evt_t ev;
  logic acc;
  logic trk_short, trk_long;

  capdec_decode u_dec (
    .code (in_word[35:32]),
    .ev   (ev),
    .be_n (out_be_n)
  );

  assign acc       = in_valid && out_ready;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = in_word[31:0];

  capdec_line #(.CNT_W(CNT_W)) u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc),
    .is_mode      (ev.mode),
    .is_fend      (ev.even_end || ev.odd_end),
    .is_sol       (ev.sol),
    .is_eol       (ev.eol),
    .is_pix       (ev.pix),
    .exp_dwords   (exp_dwords),
    .line_active  (line_active),
    .field_active (field_active),
    .short_line   (trk_short),
    .long_line    (trk_long)
  );

  assign ev_mode     = in_valid && ev.mode;
  assign mode_planar = in_valid && ev.planar;
  assign ev_sol      = in_valid && ev.sol;
  assign ev_eol      = in_valid && ev.eol;
  assign ev_even_end = in_valid && ev.even_end;
  assign ev_odd_end  = in_valid && ev.odd_end;
  assign ev_err      = in_valid && ev.err;
  assign short_line  = in_valid && trk_short;
  assign long_line   = in_valid && trk_long;

  assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_mode, ev_sol, ev_eol, ev_even_end, ev_odd_end, ev_err}));

  assert_eol_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eol |-> !out_be_n[0]);

  assert_mode_opens_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_mode) |=> field_active);

endmodule

// File: tb/capdec_top_test.sv
`timescale 1ns/1ps
module capdec_top_test;

  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [35:0] in_word = '0;
  logic [CNT_W-1:0] exp_dwords = CNT_W'(100);
  logic in_ready, out_valid;
  logic [31:0] out_data;
  logic [3:0] out_be_n;
  logic ev_mode, mode_planar, ev_sol, ev_eol, ev_even_end, ev_odd_end, ev_err;
  logic short_line, long_line, line_active, field_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  capdec_top #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_be_n(out_be_n), .exp_dwords(exp_dwords),
    .ev_mode(ev_mode), .mode_planar(mode_planar), .ev_sol(ev_sol),
    .ev_eol(ev_eol), .ev_even_end(ev_even_end), .ev_odd_end(ev_odd_end),
    .ev_err(ev_err), .short_line(short_line), .long_line(long_line),
    .line_active(line_active), .field_active(field_active)
  );

  // {code, be_n, mode planar sol eol even odd err}
  localparam logic [14:0] VEC [16] = '{
    {4'b0000, 4'b0000, 7'b0000000},
    {4'b0001, 4'b0000, 7'b0001000},
    {4'b0010, 4'b0000, 7'b0010000},
    {4'b0011, 4'b0000, 7'b0000001},
    {4'b0100, 4'b1111, 7'b0000100},
    {4'b0101, 4'b1110, 7'b0001000},
    {4'b0110, 4'b1111, 7'b1000000},
    {4'b0111, 4'b0000, 7'b0000001},
    {4'b1000, 4'b0000, 7'b0000001},
    {4'b1001, 4'b1100, 7'b0001000},
    {4'b1010, 4'b0000, 7'b0000001},
    {4'b1011, 4'b0000, 7'b0000001},
    {4'b1100, 4'b1111, 7'b0000010},
    {4'b1101, 4'b1000, 7'b0001000},
    {4'b1110, 4'b1111, 7'b1100000},
    {4'b1111, 4'b0000, 7'b0000001}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] code, input logic rdy);
    @(negedge clk);
    in_valid  = 1'b1;
    out_ready = rdy;
    in_word   = {code, 32'hC0DE_0000 | 32'(code)};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle();
    chk(line_active == 1'b0, "R10 line_active", 32'(line_active), 0);
    chk(field_active == 1'b0, "R10 field_active", 32'(field_active), 0);

    // table walk of all sixteen codes
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][14:11], 1'b1);
      chk(out_be_n == VEC[i][10:7], "R2/R3/R4/R5/R6 be_n", 32'(out_be_n), 32'(VEC[i][10:7]));
      chk({ev_mode, mode_planar, ev_sol, ev_eol, ev_even_end, ev_odd_end, ev_err} == VEC[i][6:0],
          "R2/R3/R4/R5/R6 events",
          32'({ev_mode, mode_planar, ev_sol, ev_eol, ev_even_end, ev_odd_end, ev_err}), 32'(VEC[i][6:0]));
      chk(out_data == (32'hC0DE_0000 | 32'(i)) && out_valid && in_ready, "R1 pass-through",
          out_data, 32'hC0DE_0000 | 32'(i));
    end

    // nominal line, exp 4
    exp_dwords = CNT_W'(4);
    drive(4'b1110, 1'b1);
    drive(4'b0010, 1'b1);
    idle();
    chk(line_active == 1'b1, "R9 open after start", 32'(line_active), 1);
    chk(field_active == 1'b1, "R4 field after mode", 32'(field_active), 1);
    drive(4'b0000, 1'b1);
    drive(4'b0000, 1'b1);
    chk(long_line == 1'b0, "R8 no long at pos3", 32'(long_line), 0);
    drive(4'b0001, 1'b1);
    chk(short_line == 1'b0 && long_line == 1'b0, "R7 exact line no flag", 32'(short_line), 0);
    idle();
    chk(line_active == 1'b0, "R9 closed after end", 32'(line_active), 0);

    // short line
    drive(4'b0010, 1'b1);
    drive(4'b0000, 1'b1);
    drive(4'b1001, 1'b1);
    chk(short_line == 1'b1, "R7 short line", 32'(short_line), 1);
    chk(out_be_n == 4'b1100, "R2 two bytes", 32'(out_be_n), 32'hC);

    // long line
    drive(4'b0010, 1'b1);
    drive(4'b0000, 1'b1);
    drive(4'b0000, 1'b1);
    drive(4'b0000, 1'b1);
    chk(long_line == 1'b1, "R8 long at expected count", 32'(long_line), 1);
    drive(4'b0000, 1'b1);
    chk(long_line == 1'b0, "R8 long only once", 32'(long_line), 0);
    drive(4'b0001, 1'b1);
    chk(short_line == 1'b0, "R7 no short on overlong", 32'(short_line), 0);

    // stall does not count
    drive(4'b0010, 1'b1);
    for (int k = 0; k < 3; k++) begin
      drive(4'b0000, 1'b0);
      chk(out_valid == 1'b1 && in_ready == 1'b0, "R1 stall handshake", 32'(in_ready), 0);
    end
    drive(4'b0000, 1'b1);
    chk(long_line == 1'b0, "R11 stalled words not counted", 32'(long_line), 0);
    drive(4'b0000, 1'b1);
    drive(4'b0000, 1'b1);
    chk(long_line == 1'b1, "R11 long after stall", 32'(long_line), 1);
    drive(4'b0001, 1'b1);

    // undefined code inside a line
    exp_dwords = CNT_W'(3);
    drive(4'b0010, 1'b1);
    drive(4'b0000, 1'b1);
    drive(4'b0111, 1'b1);
    chk(ev_err == 1'b1 && out_be_n == 4'b0000, "R6 err word", 32'(out_be_n), 0);
    idle();
    chk(line_active == 1'b1, "R6 line kept", 32'(line_active), 1);
    drive(4'b0000, 1'b1);
    chk(long_line == 1'b1, "R6 err not counted", 32'(long_line), 1);
    drive(4'b0001, 1'b1);

    // field end mid-line
    drive(4'b0010, 1'b1);
    drive(4'b0000, 1'b1);
    drive(4'b0100, 1'b1);
    idle();
    chk(line_active == 1'b0 && field_active == 1'b0, "R5 even end clears", 32'({line_active, field_active}), 0);
    drive(4'b0000, 1'b1);
    idle();
    chk(line_active == 1'b0, "R9 pixel outside line", 32'(line_active), 0);
    drive(4'b0110, 1'b1);
    chk(ev_mode == 1'b1 && mode_planar == 1'b0, "R4 packed mode", 32'(mode_planar), 0);
    idle();
    chk(field_active == 1'b1, "R4 field opened", 32'(field_active), 1);
    drive(4'b1100, 1'b1);
    idle();
    chk(field_active == 1'b0, "R5 odd end clears", 32'(field_active), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule